// File: doc/BRIEF.md
# Power Sign and No-Load Monitor

This block watches a stream of calibrated, signed active-power samples. Each sample comes with a valid strobe. From each sample it decides whether the power has crossed zero in the direction that software selected, and whether its magnitude lies inside a small dead band around zero. Both conditions set sticky status bits. Each status bit can drive a shared interrupt line through its own enable bit.

Every valid sample whose magnitude is outside the dead band is added to a wide signed energy register. Samples inside the dead band are dropped, so a meter with no load on it does not creep. The dead band width has three settings, and a fourth setting turns the test off. The enclosing design writes the mode inputs and reads the status, and it clears status bits by pulsing a write-one-to-clear vector.

Top module: `psnl_monitor`

## Requirements
- R1: A synchronous active-high reset sets the status vector, the interrupt and the energy register to zero. After reset the previous power sign is taken as positive.
- R2: With `dir_sel` = 0, a valid negative sample that follows a positive one sets status bit 3. A valid positive sample that follows a negative one does not set it.
- R3: With `dir_sel` = 1, a valid positive sample that follows a negative one sets status bit 3. A valid negative sample that follows a positive one does not set it.
- R4: A valid sample equal to zero raises no sign event and leaves the stored previous sign unchanged.
- R5: When `nl_mode` = 0 the no-load test is off. Status bit 0 is never set, and every valid sample is accumulated.
- R6: When `nl_mode` is 1, 2 or 3, a valid sample whose absolute value is strictly below 126, 63 or 31 respectively sets status bit 0. This includes the most negative code.
- R7: A valid sample that is not in no-load is added, sign-extended, to the 48-bit energy register. A valid sample that is in no-load leaves the register unchanged. Both outputs change on the clock edge that takes the sample.
- R8: Status bits are sticky. Writing 1 to a bit of `st_clr` clears that bit. A set event in the same cycle as its clear leaves the bit set.
- R9: `irq_o` is the OR, over the status bits, of each bit ANDed with its `irq_en` bit. It is registered alongside the status. Status bits 1 and 2 always read 0.
- R10: A cycle with `smp_valid` low changes neither the energy nor the stored sign, and sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W (24) | Signed two's complement power sample |
| nl_mode | input | 2 | No-load band select: 0 off, 1 wide, 2 medium, 3 narrow |
| dir_sel | input | 1 | Sign event direction: 0 positive to negative, 1 negative to positive |
| irq_en | input | 4 | Interrupt enables, bit 3 sign, bit 0 no-load |
| st_clr | input | 4 | Write-one-to-clear pulses for the status bits |
| status_o | output | 4 | Sticky status, bit 3 sign change, bit 0 no-load |
| irq_o | output | 1 | Registered interrupt request |
| energy_o | output | ACC_W (48) | Signed accumulated energy |

## Verification
The bound checker watches the following on every cycle:
- the state just after reset;
- that the unused status bits stay at zero;
- that a status bit holds until it is cleared;
- that the interrupt equals the enabled status;
- that energy holds still in idle cycles;
- that bit 3 rises only after a valid, nonzero sample, and bit 0 only after a valid sample with the test on.

Whether a given sample should have raised an event needs the threshold values, the stored sign and a running sum. Only the bench's sweeps can show this. The bench sweeps sample magnitudes across every band edge, in both directions and with alternating signs, and compares the results against an arithmetic model.

// File: rtl/psnl_pkg.sv
package psnl_pkg;
  localparam int STATUS_W   = 4;
  localparam int ST_NOLOAD  = 0;
  localparam int ST_SIGN    = 3;

  typedef enum logic [1:0] {
    NL_OFF    = 2'd0,
    NL_WIDE   = 2'd1,
    NL_MEDIUM = 2'd2,
    NL_NARROW = 2'd3
  } nl_mode_e;
endpackage

// File: rtl/psnl_sign_detect.sv
module psnl_sign_detect #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] data,
  input  logic                dir_sel,
  output logic                sign_evt
);
  logic prev_pos;
  logic is_neg;
  logic is_pos;

  assign is_neg = data[SAMPLE_W-1];
  assign is_pos = !data[SAMPLE_W-1] && (data != '0);

  always_comb begin
    sign_evt = 1'b0;
    if (valid) begin
      if (dir_sel) sign_evt = !prev_pos && is_pos;
      else         sign_evt = prev_pos && is_neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pos <= 1'b1;
    end else if (valid && (is_pos || is_neg)) begin
      prev_pos <= is_pos;
    end
  end
endmodule

// File: rtl/psnl_noload_cmp.sv
module psnl_noload_cmp
  import psnl_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int TH_WIDE   = 126,
  parameter int TH_MEDIUM = 63,
  parameter int TH_NARROW = 31
) (
  input  logic [SAMPLE_W-1:0] data,
  input  logic [1:0]          mode,
  output logic                below
);
  localparam int MAG_W = SAMPLE_W + 1;
  localparam logic [MAG_W-1:0] LIM_W = MAG_W'(TH_WIDE);
  localparam logic [MAG_W-1:0] LIM_M = MAG_W'(TH_MEDIUM);
  localparam logic [MAG_W-1:0] LIM_N = MAG_W'(TH_NARROW);

  logic signed [MAG_W-1:0] ext;
  logic [MAG_W-1:0]        mag;
  logic [MAG_W-1:0]        lim;

  assign ext = {data[SAMPLE_W-1], data};
  assign mag = ext[MAG_W-1] ? MAG_W'(-ext) : MAG_W'(ext);

  always_comb begin
    unique case (nl_mode_e'(mode))
      NL_WIDE:   lim = LIM_W;
      NL_MEDIUM: lim = LIM_M;
      NL_NARROW: lim = LIM_N;
      default:   lim = '0;
    endcase
  end

  assign below = (mode != NL_OFF) && (mag < lim);
endmodule

// File: rtl/psnl_energy_acc.sv
module psnl_energy_acc #(
  parameter int SAMPLE_W = 24,
  parameter int ACC_W    = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                add_en,
  input  logic [SAMPLE_W-1:0] data,
  output logic [ACC_W-1:0]    energy
);
  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic [ACC_W-1:0] addend;
  assign addend = {{EXT_W{data[SAMPLE_W-1]}}, data};

  always_ff @(posedge clk) begin
    if (rst)         energy <= '0;
    else if (add_en) energy <= energy + addend;
  end
endmodule

// File: rtl/psnl_status_irq.sv
module psnl_status_irq #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] status,
  output logic             irq
);
  logic [WIDTH-1:0] status_n;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign status_n[b] = set[b] | (status[b] & ~clr[b]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= |(status_n & en);
    end
  end
endmodule

// File: rtl/psnl_monitor.sv
module psnl_monitor
  import psnl_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int ACC_W     = 48,
  parameter int TH_WIDE   = 126,
  parameter int TH_MEDIUM = 63,
  parameter int TH_NARROW = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [1:0]          nl_mode,
  input  logic                dir_sel,
  input  logic [3:0]          irq_en,
  input  logic [3:0]          st_clr,
  output logic [3:0]          status_o,
  output logic                irq_o,
  output logic [ACC_W-1:0]    energy_o
);
  logic                sign_evt;
  logic                below;
  logic                nl_evt;
  logic [STATUS_W-1:0] set_vec;

  psnl_sign_detect #(.SAMPLE_W(SAMPLE_W)) u_sign (
    .clk(clk), .rst(rst), .valid(smp_valid), .data(smp_data),
    .dir_sel(dir_sel), .sign_evt(sign_evt)
  );

  psnl_noload_cmp #(
    .SAMPLE_W(SAMPLE_W), .TH_WIDE(TH_WIDE),
    .TH_MEDIUM(TH_MEDIUM), .TH_NARROW(TH_NARROW)
  ) u_nl (
    .data(smp_data), .mode(nl_mode), .below(below)
  );

  assign nl_evt = smp_valid && below;

  always_comb begin
    set_vec            = '0;
    set_vec[ST_SIGN]   = sign_evt;
    set_vec[ST_NOLOAD] = nl_evt;
  end

  psnl_energy_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .add_en(smp_valid && !below),
    .data(smp_data), .energy(energy_o)
  );

  psnl_status_irq #(.WIDTH(STATUS_W)) u_st (
    .clk(clk), .rst(rst), .set(set_vec), .clr(st_clr), .en(irq_en),
    .status(status_o), .irq(irq_o)
  );
endmodule

// File: rtl/psnl_monitor_chk.sv
module psnl_monitor_chk #(
  parameter int SAMPLE_W = 24,
  parameter int ACC_W    = 48
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [1:0]          nl_mode,
  input logic [3:0]          irq_en,
  input logic [3:0]          st_clr,
  input logic [3:0]          status_o,
  input logic                irq_o,
  input logic [ACC_W-1:0]    energy_o
);
  logic boot = 1'b0;
  always_ff @(posedge clk) boot <= 1'b1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!boot)
    $past(rst) |-> (status_o == 4'd0 && !irq_o && energy_o == '0));

  p_sign_needs_sample_r2: assert property (@(posedge clk) disable iff (rst || !boot)
    $rose(status_o[3]) |-> ($past(smp_valid) && $past(smp_data) != '0));

  p_noload_needs_mode_r6: assert property (@(posedge clk) disable iff (rst || !boot)
    $rose(status_o[0]) |-> ($past(smp_valid) && $past(nl_mode) != 2'd0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst || !boot)
    (status_o[3] && !st_clr[3]) |=> status_o[3]);

  p_sticky_nl_r8: assert property (@(posedge clk) disable iff (rst || !boot)
    (status_o[0] && !st_clr[0]) |=> status_o[0]);

  p_irq_map_r9: assert property (@(posedge clk) disable iff (rst || !boot)
    !$past(rst) |-> (irq_o == |(status_o & $past(irq_en))));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst || !boot)
    status_o[2:1] == 2'b00);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst || !boot)
    (!$past(smp_valid) && !$past(rst)) |-> $stable(energy_o));
endmodule

bind psnl_monitor psnl_monitor_chk #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
  .nl_mode(nl_mode), .irq_en(irq_en), .st_clr(st_clr),
  .status_o(status_o), .irq_o(irq_o), .energy_o(energy_o)
);

// File: tb/psnl_monitor_bench.sv
module psnl_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 24;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [1:0]    nl_mode = 2'd0;
  logic          dir_sel = 1'b0;
  logic [3:0]    irq_en = 4'd0;
  logic [3:0]    st_clr = 4'd0;
  logic [3:0]    status_o;
  logic          irq_o;
  logic [AW-1:0] energy_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit       m_prev_pos;
  logic [3:0] m_st;
  logic     m_irq;
  longint   m_energy;

  always #(CLK_PERIOD/2) clk = ~clk;

  psnl_monitor u_psnl_monitor (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .nl_mode(nl_mode), .dir_sel(dir_sel), .irq_en(irq_en), .st_clr(st_clr),
    .status_o(status_o), .irq_o(irq_o), .energy_o(energy_o)
  );

  function automatic int band(input logic [1:0] m);
    case (m)
      2'd1: return 126;
      2'd2: return 63;
      2'd3: return 31;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "status", longint'(status_o), longint'(m_st));
    check(tag, "irq", longint'(irq_o), longint'(m_irq));
    check(tag, "energy", longint'($signed(energy_o)), m_energy);
  endtask

  task automatic step(input bit v, input int d, input logic [3:0] clr, input string tag);
    logic [3:0] set;
    int mag;
    @(negedge clk);
    smp_valid = v;
    smp_data  = d[SW-1:0];
    st_clr    = clr;
    set = 4'd0;
    if (v) begin
      if (dir_sel) set[3] = !m_prev_pos && (d > 0);
      else         set[3] = m_prev_pos && (d < 0);
      if (d != 0) m_prev_pos = (d > 0);
      mag = (d < 0) ? -d : d;
      set[0] = (nl_mode != 2'd0) && (mag < band(nl_mode));
      if (!set[0]) m_energy += longint'(d);
    end
    m_st  = (m_st & ~clr) | set;
    m_irq = |(m_st & irq_en);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a valid sample
    smp_valid = 1'b1;
    smp_data  = SW'(-5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    smp_valid = 1'b0;
    m_prev_pos = 1'b1;
    m_st = 4'd0;
    m_irq = 1'b0;
    m_energy = 0;
    #1;
    check_all("R1");

    irq_en = 4'b1001;
    // R4: zero keeps sign; first negative after reset is an event
    step(1'b1, 0, 4'd0, "R4");
    step(1'b1, -3, 4'd0, "R4");
    step(1'b1, 0, 4'b1001, "R4");
    step(1'b1, 4, 4'd0, "R4");
    step(1'b1, 0, 4'd0, "R4");
    step(1'b1, -2, 4'd0, "R4");
    // R8: sticky, clear, set beats clear
    step(1'b1, 5, 4'd0, "R8");
    step(1'b1, 7, 4'd0, "R8");
    step(1'b0, 0, 4'b1000, "R8");
    step(1'b1, -1, 4'b1000, "R8");
    step(1'b0, 0, 4'b1001, "R8");
    // R10: idle cycles touch nothing, stored sign stays negative
    step(1'b0, -99999, 4'd0, "R10");
    step(1'b0, 50, 4'd0, "R10");
    step(1'b1, -2, 4'd0, "R10");
    // R9: every enable pattern against a set sign bit
    step(1'b1, 9, 4'd0, "R9");
    step(1'b1, -9, 4'd0, "R9");
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e);
      step(1'b0, 0, 4'd0, "R9");
    end
    // R9: bit 0 alone
    step(1'b0, 0, 4'b1111, "R9");
    nl_mode = 2'd1;
    for (int e = 0; e < 16; e++) begin
      irq_en = 4'(e);
      step(1'b1, -1, 4'b1000, "R9");
    end

    // R2 R3 R5 R6 R7: sweep directions, bands and alternating magnitudes
    irq_en = 4'b1001;
    for (int dr = 0; dr < 2; dr++) begin
      for (int md = 0; md < 4; md++) begin
        dir_sel = dr[0];
        nl_mode = 2'(md);
        for (int k = 0; k < 262; k++) begin
          int mag;
          string tg;
          mag = k / 2;
          tg = $sformatf("%s/%s/R7", dr ? "R3" : "R2", md == 0 ? "R5" : "R6");
          step(1'b1, (k % 2) ? -mag : mag, 4'b1111, tg);
        end
      end
    end

    // R6 R7: large codes and band edges in narrow mode
    dir_sel = 1'b0;
    nl_mode = 2'd3;
    step(1'b1, 838861, 4'b1111, "R7");
    step(1'b1, -8388608, 4'b1111, "R6");
    step(1'b1, 8388607, 4'b1111, "R7");
    step(1'b1, -31, 4'b1111, "R6");
    step(1'b1, -30, 4'b1111, "R6");
    step(1'b1, 31, 4'b1111, "R6");
    step(1'b1, 30, 4'b1111, "R6");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule